// File: doc/BRIEF.md
# Programmable Duty-Cycle Clock Prescaler

This block derives a slow conversion clock for a successive-approximation converter from a faster clock. The length of the high phase and the length of the low phase are each programmed through their own field. Together they set both the frequency and the duty cycle of the output. A single control bit can stretch the high phase by half a system-clock period.

Half-period resolution needs a clock that runs at twice the system rate. The block runs on that clock and counts half-cycles of the system clock. A single down counter times both phases. When the counter reaches zero, it either clears the output clock, ending the high phase, or sets it, starting the next high phase. Each time the output clock goes high, a pulse one fast cycle wide marks the edge for the converter's sequencer.

All settings are sampled only when a high phase begins, so a period already in progress is never cut short. While the block is disabled, the output stays low and the counter stays cleared.

Top module: `duty_clk_prescaler`

## Requirements
- R1: While reset is asserted, or while the enable is low, the divided clock and the edge pulse are both 0.
- R2: When the enable is sampled high while the block is idle, the divided clock and the edge pulse go to 1 on the next fast clock edge.
- R3: With the half-cycle bit at 0, the high phase lasts 2*(H+1) fast cycles, where H is the 5-bit high-time field (0 to 31).
- R4: The low phase lasts 2*(L+1) fast cycles, where L is the 3-bit low-time field (0 to 7).
- R5: With the half-cycle bit at 1, the high phase lasts 2*(H+1)+1 fast cycles.
- R6: The shortest period (H=0, L=0, half bit 0) is 4 fast cycles, which is 2 system cycles. The longest period with the half bit at 0 (H=31, L=7) is 80 fast cycles, which is 40 system cycles.
- R7: The high-time field, the low-time field and the half-cycle bit are sampled only when a high phase starts. A change during a period affects only the following period.
- R8: The edge pulse is 1 for exactly one fast cycle, in the cycle where the divided clock changes from 0 to 1, and is 0 at every other time.
- R9: Dropping the enable in the middle of a period forces the divided clock low on the next edge. Raising the enable again starts a fresh, full high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast clock, twice the system rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Enable; low holds the output clock low |
| high_sel_i | input | 5 | High-time field H |
| low_sel_i | input | 3 | Low-time field L |
| half_add_i | input | 1 | Adds one half system cycle to the high phase |
| div_clk_o | output | 1 | Divided conversion clock |
| div_rise_o | output | 1 | One-cycle pulse at each rising edge of div_clk_o |

## Verification
The bench runs the divider with a mid-range setting, the same setting with the half bit set, both extreme settings, and an asymmetric setting. Each of these patterns separates the high-phase count from the low-phase count, and the odd-length high phase shows whether the half bit has any effect. Every new setting is applied just after a rising edge. A design that picks up fields mid-period therefore produces a wrong length in the current period rather than the next one. A disable in the middle of the high phase, followed by a restart, checks that the output is forced low and that a full first phase follows.

// File: rtl/dcp_pkg.sv
package dcp_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HIGH = 2'd1,
        PH_LOW  = 2'd2
    } phase_e;

endpackage

// File: rtl/dcp_len_calc.sv
module dcp_len_calc #(
    parameter int HI_W  = 5,
    parameter int LO_W  = 3,
    parameter int CNT_W = 7
) (
    input  logic [HI_W-1:0]  hi_field_i,
    input  logic [LO_W-1:0]  lo_field_i,
    input  logic             half_i,
    output logic [CNT_W-1:0] hi_load_o,
    output logic [CNT_W-1:0] lo_load_o
);

    // Phase length in fast cycles minus one: 2*(field+1)-1 = 2*field+1,
    // plus one extra fast cycle on the high side when the half bit is set.
    always_comb begin
        hi_load_o = CNT_W'({hi_field_i, 1'b1}) + CNT_W'(half_i);
        lo_load_o = CNT_W'({lo_field_i, 1'b1});
    end

endmodule

// File: rtl/dcp_phase_ctrl.sv
module dcp_phase_ctrl
    import dcp_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic [CNT_W-1:0] hi_load_i,
    input  logic [CNT_W-1:0] lo_load_i,
    output logic             clk_o,
    output logic             rise_o
);

    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] lo_hold;
        logic             clk;
        logic             rise;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.rise = 1'b0;
        if (!en_i) begin
            st_d.phase = PH_IDLE;
            st_d.cnt   = '0;
            st_d.clk   = 1'b0;
        end else begin
            unique case (st_q.phase)
                PH_HIGH: begin
                    if (st_q.cnt == '0) begin
                        st_d.phase = PH_LOW;
                        st_d.cnt   = st_q.lo_hold;
                        st_d.clk   = 1'b0;
                    end else begin
                        st_d.cnt = st_q.cnt - 1'b1;
                    end
                end
                PH_LOW: begin
                    if (st_q.cnt == '0) begin
                        st_d.phase   = PH_HIGH;
                        st_d.cnt     = hi_load_i;
                        st_d.lo_hold = lo_load_i;
                        st_d.clk     = 1'b1;
                        st_d.rise    = 1'b1;
                    end else begin
                        st_d.cnt = st_q.cnt - 1'b1;
                    end
                end
                default: begin
                    st_d.phase   = PH_HIGH;
                    st_d.cnt     = hi_load_i;
                    st_d.lo_hold = lo_load_i;
                    st_d.clk     = 1'b1;
                    st_d.rise    = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{phase: PH_IDLE, cnt: '0, lo_hold: '0, clk: 1'b0, rise: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign clk_o  = st_q.clk;
    assign rise_o = st_q.rise;

    assert_off_when_disabled_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> (!clk_o && !rise_o));

    assert_start_from_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.phase == PH_IDLE && en_i) |=> (clk_o && rise_o));

    assert_high_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rise_o |-> (st_q.cnt == $past(hi_load_i)));

    assert_low_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.phase == PH_HIGH) |=> $stable(st_q.lo_hold));

    assert_rise_on_edge_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(clk_o) |-> rise_o);

    assert_rise_needs_clk_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rise_o |-> clk_o);

    assert_rise_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rise_o |=> !rise_o);

endmodule

// File: rtl/duty_clk_prescaler.sv
module duty_clk_prescaler #(
    parameter int HI_W = 5,
    parameter int LO_W = 3
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            en_i,
    input  logic [HI_W-1:0] high_sel_i,
    input  logic [LO_W-1:0] low_sel_i,
    input  logic            half_add_i,
    output logic            div_clk_o,
    output logic            div_rise_o
);

    // Longest reload value is 2*(2**HI_W - 1) + 2; size the counter for it.
    localparam int CNT_W = $clog2(2 * (1 << HI_W) + 2);

    logic [CNT_W-1:0] hi_load;
    logic [CNT_W-1:0] lo_load;

    dcp_len_calc #(
        .HI_W  (HI_W),
        .LO_W  (LO_W),
        .CNT_W (CNT_W)
    ) u_len (
        .hi_field_i (high_sel_i),
        .lo_field_i (low_sel_i),
        .half_i     (half_add_i),
        .hi_load_o  (hi_load),
        .lo_load_o  (lo_load)
    );

    dcp_phase_ctrl #(
        .CNT_W (CNT_W)
    ) u_phase (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .en_i      (en_i),
        .hi_load_i (hi_load),
        .lo_load_i (lo_load),
        .clk_o     (div_clk_o),
        .rise_o    (div_rise_o)
    );

endmodule

// File: tb/duty_clk_prescaler_bench.sv
`timescale 1ns/1ps
module duty_clk_prescaler_bench;

    logic       clk;
    logic       rst_n;
    logic       en;
    logic [4:0] hsel;
    logic [2:0] lsel;
    logic       half;
    logic       div_clk;
    logic       div_rise;

    int checks   = 0;
    int failures = 0;

    typedef struct {
        int hi;
        int lo;
        int cfg;
    } exp_t;

    exp_t sb_q[$];

    duty_clk_prescaler u_duty_clk_prescaler (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .en_i       (en),
        .high_sel_i (hsel),
        .low_sel_i  (lsel),
        .half_add_i (half),
        .div_clk_o  (div_clk),
        .div_rise_o (div_rise)
    );

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: run hung, actual=running expected=done");
        summary();
    end

    // Monitor: measures each completed period and compares with the scoreboard.
    int  hi_n = 0;
    int  lo_n = 0;
    bit  in_per = 0;
    logic prev_clk = 1'b0;

    always @(negedge clk) begin
        if (!rst_n || !en) begin
            in_per = 0;
            hi_n   = 0;
            lo_n   = 0;
            sb_q.delete();
        end else begin
            if (div_rise !== (div_clk && !prev_clk)) begin
                failures++;
                $display("FAIL R8 pulse: actual=%0b expected=%0b", div_rise, div_clk && !prev_clk);
            end
            if (div_rise) begin
                checks++;
                if (in_per) begin
                    checks++;
                    if (sb_q.size() == 0) begin
                        failures++;
                        $display("FAIL R3/R4/R5/R6/R7 scoreboard empty: actual=%0d/%0d expected=none", hi_n, lo_n);
                    end else begin
                        exp_t e;
                        e = sb_q.pop_front();
                        if (e.hi != hi_n || e.lo != lo_n) begin
                            failures++;
                            $display("FAIL R3/R4/R5/R6/R7 cfg=%0d hi/lo: actual=%0d/%0d expected=%0d/%0d",
                                     e.cfg, hi_n, lo_n, e.hi, e.lo);
                        end
                    end
                end
                in_per = 1;
                hi_n   = 1;
                lo_n   = 0;
            end else if (in_per) begin
                if (div_clk) hi_n++;
                else         lo_n++;
            end
        end
        prev_clk = div_clk;
    end

    task automatic check_bit(input string tag, input logic act, input logic exp_v);
        checks++;
        if (act !== exp_v) begin
            failures++;
            $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp_v);
        end
    endtask

    task automatic push_exp(input int h, input int l, input bit hb, input int id);
        exp_t e;
        e.hi  = 2 * (h + 1) + (hb ? 1 : 0);
        e.lo  = 2 * (l + 1);
        e.cfg = id;
        sb_q.push_back(e);
    endtask

    task automatic wait_rise();
        do @(negedge clk); while (!div_rise);
    endtask

    // Drive fields for the next period right after a rising edge (mid-period).
    task automatic run_cfg(input int h, input int l, input bit hb, input int id, input int n);
        for (int k = 0; k < n; k++) begin
            hsel = 5'(h);
            lsel = 3'(l);
            half = hb;
            push_exp(h, l, hb, id);
            wait_rise();
        end
    endtask

    task automatic start(input int h, input int l, input bit hb, input int id);
        @(posedge clk);
        #1;
        hsel = 5'(h);
        lsel = 3'(l);
        half = hb;
        en   = 1'b1;
        push_exp(h, l, hb, id);
        @(negedge clk);
        check_bit("R2 clk not yet high", div_clk, 1'b0);
        @(negedge clk);
        check_bit("R2 clk high after enable", div_clk, 1'b1);
        check_bit("R2 pulse after enable", div_rise, 1'b1);
    endtask

    initial begin
        rst_n = 1'b0;
        en    = 1'b0;
        hsel  = 5'd7;
        lsel  = 3'd3;
        half  = 1'b0;
        repeat (3) @(negedge clk);
        check_bit("R1 reset clk", div_clk, 1'b0);
        check_bit("R1 reset pulse", div_rise, 1'b0);
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check_bit("R1 disabled clk", div_clk, 1'b0);
        check_bit("R1 disabled pulse", div_rise, 1'b0);

        start(3, 2, 1'b0, 1);          // R2
        run_cfg(3, 2, 1'b0, 1, 3);     // R3 R4
        run_cfg(3, 2, 1'b1, 2, 2);     // R5, switched mid-period: R7
        run_cfg(0, 0, 1'b0, 3, 3);     // R6 shortest period
        run_cfg(31, 7, 1'b0, 4, 2);    // R6 longest period
        run_cfg(31, 7, 1'b1, 5, 1);    // R5 at the top of the range
        run_cfg(10, 5, 1'b0, 6, 2);    // R7 asymmetric setting

        // R9: drop enable in the middle of the high phase.
        @(posedge clk);
        #1;
        en   = 1'b0;
        hsel = 5'd1;
        lsel = 3'd3;
        @(negedge clk);
        @(negedge clk);
        check_bit("R9 forced low", div_clk, 1'b0);
        check_bit("R9 no pulse", div_rise, 1'b0);
        repeat (5) @(negedge clk);
        check_bit("R1 held low while disabled", div_clk, 1'b0);

        start(1, 3, 1'b0, 7);          // R9 fresh restart
        run_cfg(1, 3, 1'b0, 7, 2);
        wait_rise();

        @(posedge clk);
        #1;
        en = 1'b0;
        repeat (3) @(negedge clk);
        summary();
    end

endmodule